// File: doc/BRIEF.md
# Bunch-structure marker generator

This block counts RF buckets around one turn of a circular machine and derives, bucket by bucket, the markers that describe how the beam is laid out. The turn holds three super bunches of twelve filled crossings each, and a gap follows every super bunch. The outputs are a once-per-turn beginning-of-turn marker and an interaction marker for each filled crossing. Two gap markers follow: the cosmic-gap marker covers the gaps after the first and second super bunches, and the sync-gap marker covers the gap ahead of the first super bunch. The last output is a spare marker that keeps its crossing cadence through the gaps.

All markers are placed relative to a nominal pattern. The pattern is moved as a whole by the sum of three signed inputs: a global offset, a system offset and a per-signal delay. All positions wrap modulo the turn length, so a window may straddle the end of the turn. A turn-marker input resynchronises the counter to bucket 1. The current bucket index is driven out with the markers, so a consumer can see which bucket each marker value applies to.

Top module: `bsm_gen`

## Requirements
- R1: While `rst` is high at a rising edge, the next state shows `bucket_o` = 1 and every marker output low.
- R2: Outside reset and realignment, `bucket_o` advances by one on every rising edge through 1..1113, and after 1113 it returns to 1.
- R3: When `turn_in` is high at a rising edge (and `rst` is low), `bucket_o` becomes 1 on that edge, and the markers show the values for bucket 1.
- R4: Let S be the signed two's-complement sum `ofs_global + ofs_system + ofs_delay`. A marker whose nominal position is p is asserted at bucket ((p + S - 1) mod 1113) + 1. A window whose wrapped end lies before its wrapped start spans the turn boundary.
- R5: `xing_o` is high for 7 buckets starting at each of the 36 nominal crossings. These lie at 140 + 371·s + 21·k, for s in 0..2 and k in 0..11.
- R6: `cosmic_o` is high over nominal buckets 392..510 and 763..881.
- R7: `syncgap_o` is high over nominal buckets 21..139, once per turn.
- R8: `bot_o` is high over nominal buckets 98..104, 7 buckets once per turn.
- R9: `spare_o` is high for 7 buckets at every crossing of R5, and it also fires inside each gap. The gap pulses start at nominal 392, 413, 434, 448, 469 and 490, and at those positions plus 371 and plus 742, taken modulo 1113. One step in each gap is 14 buckets instead of 21.
- R10: The markers are registered together with `bucket_o` and always describe the bucket shown. A change of any offset takes effect on the first rising edge after it is applied.
- R11: `xing_o` is never high together with `cosmic_o` or `syncgap_o`, and `cosmic_o` and `syncgap_o` are never both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | RF bucket clock |
| rst | input | 1 | Synchronous reset, active high |
| turn_in | input | 1 | Realign: the next bucket is bucket 1 |
| ofs_global | input | 12 | Signed global offset |
| ofs_system | input | 12 | Signed system offset |
| ofs_delay | input | 12 | Signed per-signal delay |
| bucket_o | output | 11 | Current bucket index, 1..1113 |
| bot_o | output | 1 | Beginning-of-turn marker |
| xing_o | output | 1 | Interaction (filled crossing) marker |
| cosmic_o | output | 1 | Marker for the two inner gaps |
| syncgap_o | output | 1 | Marker for the gap before the first super bunch |
| spare_o | output | 1 | Crossing-cadence marker that continues through the gaps |

## Verification
Every result is due exactly one rising edge after the stimulus that caused it. This holds for reset, for a realign pulse and for an offset change: in each case the new bucket index and the markers computed for it appear together on that edge. The bench applies inputs just after a falling edge and advances its reference model for the edge that follows. It then compares all six outputs at the next falling edge, half a period after they settle, so each comparison lines up with the single edge that produced it. Edge positions are checked over two full turns at each of four offset settings, one of which wraps the windows across the turn boundary.

// File: rtl/bsm_pkg.sv
package bsm_pkg;

    typedef struct packed {
        logic bot;
        logic xing;
        logic cosmic;
        logic syncgap;
        logic spare;
    } bsm_marks_t;

    // Non-negative remainder of x by len, result in 0..len-1.
    function automatic int wrap_idx(input int x, input int len);
        int m;
        m = x % len;
        if (m < 0) m = m + len;
        return m;
    endfunction

endpackage

// File: rtl/bsm_phase.sv
// Maps a physical bucket into nominal pattern coordinates and splits it
// into a super-bunch third and a residue measured from that third's first crossing.
module bsm_phase
    import bsm_pkg::*;
#(
    parameter int TURN_LEN   = 1113,
    parameter int NUM_SB     = 3,
    parameter int FIRST_XING = 140,
    parameter int BW         = $clog2(TURN_LEN + 1),
    parameter int SW         = 14,
    parameter int TW         = $clog2(NUM_SB + 1)
) (
    input  logic [BW-1:0]        bucket,
    input  logic signed [SW-1:0] shift,
    output logic [BW-1:0]        vpos,
    output logic [BW-1:0]        resid,
    output logic [TW-1:0]        third
);
    localparam int THIRD = TURN_LEN / NUM_SB;

    always_comb begin
        int vi;
        int wi;
        int ti;
        vi    = wrap_idx(int'(bucket) - 1 - int'(shift), TURN_LEN) + 1;
        wi    = wrap_idx(vi - FIRST_XING, TURN_LEN);
        ti    = wi / THIRD;
        vpos  = BW'(vi);
        third = TW'(ti);
        resid = BW'(wi - ti * THIRD);
    end

endmodule

// File: rtl/bsm_decode.sv
// Derives all markers from the nominal position, third index and residue.
module bsm_decode
    import bsm_pkg::*;
#(
    parameter int TURN_LEN      = 1113,
    parameter int NUM_SB        = 3,
    parameter int XINGS         = 12,
    parameter int SPACING       = 21,
    parameter int TICK          = 7,
    parameter int BOT_POS       = 98,
    parameter int STUTTER_AFTER = 3,
    parameter int BW            = $clog2(TURN_LEN + 1),
    parameter int TW            = $clog2(NUM_SB + 1)
) (
    input  logic [BW-1:0] vpos,
    input  logic [BW-1:0] resid,
    input  logic [TW-1:0] third,
    output bsm_marks_t    marks
);
    localparam int THIRD   = TURN_LEN / NUM_SB;
    localparam int TRAIN   = XINGS * SPACING;
    localparam int SHIFT_D = SPACING - (THIRD % SPACING);
    localparam int SPLIT   = TRAIN + STUTTER_AFTER * SPACING - SHIFT_D;

    always_comb begin
        int r;
        int t;
        int bd;
        r  = int'(resid);
        t  = int'(third);
        bd = wrap_idx(int'(vpos) - BOT_POS, TURN_LEN);
        marks.bot     = bd < TICK;
        marks.xing    = (r < TRAIN) && ((r % SPACING) < TICK);
        marks.cosmic  = (r >= TRAIN) && (t != NUM_SB - 1);
        marks.syncgap = (r >= TRAIN) && (t == NUM_SB - 1);
        // Before the split point the cadence runs on; after it, the phase
        // is advanced by SHIFT_D so the next third starts aligned.
        if (r < SPLIT)
            marks.spare = (r % SPACING) < TICK;
        else
            marks.spare = ((r + SHIFT_D) % SPACING) < TICK;
    end

endmodule

// File: rtl/bsm_gen.sv
module bsm_gen
    import bsm_pkg::*;
#(
    parameter int TURN_LEN      = 1113,
    parameter int NUM_SB        = 3,
    parameter int XINGS         = 12,
    parameter int SPACING       = 21,
    parameter int TICK          = 7,
    parameter int FIRST_XING    = 140,
    parameter int BOT_POS       = 98,
    parameter int STUTTER_AFTER = 3,
    parameter int OFS_W         = 12,
    parameter int BW            = $clog2(TURN_LEN + 1)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    turn_in,
    input  logic signed [OFS_W-1:0] ofs_global,
    input  logic signed [OFS_W-1:0] ofs_system,
    input  logic signed [OFS_W-1:0] ofs_delay,
    output logic [BW-1:0]           bucket_o,
    output logic                    bot_o,
    output logic                    xing_o,
    output logic                    cosmic_o,
    output logic                    syncgap_o,
    output logic                    spare_o
);
    localparam int SW = OFS_W + 2;
    localparam int TW = $clog2(NUM_SB + 1);

    typedef struct packed {
        logic [BW-1:0] bucket;
        bsm_marks_t    marks;
    } state_t;

    state_t               st_d, st_q;
    logic [BW-1:0]        bucket_d;
    logic signed [SW-1:0] shift_d;
    logic [BW-1:0]        vpos_d, resid_d;
    logic [TW-1:0]        third_d;
    bsm_marks_t           marks_d;

    // Next bucket index; the decode path below evaluates it.
    always_comb begin
        if (rst || turn_in)
            bucket_d = BW'(1);
        else if (int'(st_q.bucket) >= TURN_LEN)
            bucket_d = BW'(1);
        else
            bucket_d = st_q.bucket + BW'(1);
        shift_d = SW'(int'(ofs_global) + int'(ofs_system) + int'(ofs_delay));
    end

    bsm_phase #(
        .TURN_LEN(TURN_LEN), .NUM_SB(NUM_SB), .FIRST_XING(FIRST_XING),
        .BW(BW), .SW(SW), .TW(TW)
    ) u_phase (
        .bucket(bucket_d), .shift(shift_d),
        .vpos(vpos_d), .resid(resid_d), .third(third_d)
    );

    bsm_decode #(
        .TURN_LEN(TURN_LEN), .NUM_SB(NUM_SB), .XINGS(XINGS), .SPACING(SPACING),
        .TICK(TICK), .BOT_POS(BOT_POS), .STUTTER_AFTER(STUTTER_AFTER),
        .BW(BW), .TW(TW)
    ) u_decode (
        .vpos(vpos_d), .resid(resid_d), .third(third_d), .marks(marks_d)
    );

    always_comb begin
        st_d.bucket = bucket_d;
        st_d.marks  = rst ? '0 : marks_d;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign bucket_o  = st_q.bucket;
    assign bot_o     = st_q.marks.bot;
    assign xing_o    = st_q.marks.xing;
    assign cosmic_o  = st_q.marks.cosmic;
    assign syncgap_o = st_q.marks.syncgap;
    assign spare_o   = st_q.marks.spare;

    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (bucket_o == BW'(1)) && !bot_o && !xing_o && !cosmic_o && !syncgap_o && !spare_o);

    a_r2_step: assert property (@(posedge clk) disable iff (rst)
        (!turn_in && int'(bucket_o) < TURN_LEN) |=> bucket_o == $past(bucket_o) + BW'(1));

    a_r2_wrap: assert property (@(posedge clk) disable iff (rst)
        (!turn_in && int'(bucket_o) == TURN_LEN) |=> bucket_o == BW'(1));

    a_r2_range: assert property (@(posedge clk) disable iff (rst)
        (bucket_o >= BW'(1)) && (int'(bucket_o) <= TURN_LEN));

    a_r3_realign: assert property (@(posedge clk) disable iff (rst)
        turn_in |=> bucket_o == BW'(1));

    a_r9_spare_covers_xing: assert property (@(posedge clk) disable iff (rst)
        xing_o |-> spare_o);

    a_r11_gap_excludes_xing: assert property (@(posedge clk) disable iff (rst)
        xing_o |-> !(cosmic_o || syncgap_o));

    a_r11_one_gap: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cosmic_o, syncgap_o}));

endmodule

// File: tb/bsm_gen_tb.sv
module bsm_gen_tb;
    localparam int TL = 1113;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic turn_in = 1'b0;
    logic signed [11:0] og = 12'sd1, os = -12'sd5, od = -12'sd31;
    logic [10:0] bucket_o;
    logic bot_o, xing_o, cosmic_o, syncgap_o, spare_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    bit p_bot[1:TL], p_x[1:TL], p_c[1:TL], p_s[1:TL], p_sp[1:TL];
    int eb;
    bit e_bot, e_x, e_c, e_s, e_sp;

    always #10 clk = ~clk;

    bsm_gen u_dut (
        .clk(clk), .rst(rst), .turn_in(turn_in),
        .ofs_global(og), .ofs_system(os), .ofs_delay(od),
        .bucket_o(bucket_o), .bot_o(bot_o), .xing_o(xing_o),
        .cosmic_o(cosmic_o), .syncgap_o(syncgap_o), .spare_o(spare_o)
    );

    function automatic int wrap1(input int x);
        int m;
        m = (x - 1) % TL;
        if (m < 0) m = m + TL;
        return m + 1;
    endfunction

    task automatic mark_win(input int start, input int len, input int sel);
        for (int i = 0; i < len; i++) begin
            int b;
            b = wrap1(start + i);
            case (sel)
                0: p_bot[b] = 1;
                1: p_x[b]   = 1;
                2: p_c[b]   = 1;
                3: p_s[b]   = 1;
                default: p_sp[b] = 1;
            endcase
        end
    endtask

    task automatic build_tables();
        int gp[6] = '{392, 413, 434, 448, 469, 490};
        for (int b = 1; b <= TL; b++) begin
            p_bot[b] = 0; p_x[b] = 0; p_c[b] = 0; p_s[b] = 0; p_sp[b] = 0;
        end
        mark_win(98, 7, 0);                         // R8
        for (int s = 0; s < 3; s++)
            for (int k = 0; k < 12; k++) begin
                mark_win(140 + 371 * s + 21 * k, 7, 1);   // R5
                mark_win(140 + 371 * s + 21 * k, 7, 4);   // R9 crossings
            end
        mark_win(392, 119, 2);                      // R6
        mark_win(763, 119, 2);
        mark_win(21, 119, 3);                       // R7
        for (int g = 0; g < 3; g++)
            for (int j = 0; j < 6; j++)
                mark_win(gp[j] + 371 * g, 7, 4);    // R9 gap pulses
    endtask

    task automatic chk(input bit ok, input string what, input int got, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s at model bucket %0d: got %0d expected %0d", what, eb, got, exp);
        end
    endtask

    task automatic tick(input bit t);
        int s, v;
        turn_in = t;
        if (rst) begin
            eb = 1; e_bot = 0; e_x = 0; e_c = 0; e_s = 0; e_sp = 0;
        end else begin
            eb = t ? 1 : ((eb == TL) ? 1 : eb + 1);
            s = int'(og) + int'(os) + int'(od);
            v = wrap1(eb - s);                      // R4 placement
            e_bot = p_bot[v]; e_x = p_x[v]; e_c = p_c[v]; e_s = p_s[v]; e_sp = p_sp[v];
        end
        @(negedge clk);
        chk(int'(bucket_o) == eb, "R2 bucket index (R3 realign, R10 timing)", int'(bucket_o), eb);
        chk(bot_o == e_bot, "R8 begin-of-turn (R4 offsets, R10 timing)", bot_o, e_bot);
        chk(xing_o == e_x, "R5 interaction (R4 offsets, R10 timing)", xing_o, e_x);
        chk(cosmic_o == e_c, "R6 cosmic gap (R4 offsets, R10 timing)", cosmic_o, e_c);
        chk(syncgap_o == e_s, "R7 sync gap (R4 offsets, R10 timing)", syncgap_o, e_s);
        chk(spare_o == e_sp, "R9 spare (R4 offsets, R10 timing)", spare_o, e_sp);
        chk(!(xing_o && (cosmic_o || syncgap_o)) && !(cosmic_o && syncgap_o),
            "R11 marker exclusivity", {xing_o, cosmic_o, syncgap_o}, 0);
    endtask

    task automatic run_turns(input int n);
        for (int i = 0; i < n; i++) tick(0);
    endtask

    initial begin
        build_tables();
        eb = 1;
        @(negedge clk);
        rst = 1;
        tick(0); tick(0); tick(0);
        // R1: reset state
        chk(bucket_o == 11'd1 && !bot_o && !xing_o && !cosmic_o && !syncgap_o && !spare_o,
            "R1 reset state", {bucket_o, bot_o, xing_o, cosmic_o, syncgap_o, spare_o}, 11'd1 << 5);
        rst = 0;
        // Default offsets: sum -35
        run_turns(2 * TL + 5);
        // R3: realign mid-turn
        while (eb != 500) tick(0);
        tick(1);
        chk(bucket_o == 11'd1, "R3 realign to bucket 1", int'(bucket_o), 1);
        run_turns(30);
        // R4: zero offsets, crossing windows wrap past the turn end
        og = 12'sd0; os = 12'sd0; od = 12'sd0;
        run_turns(2 * TL + 3);
        // R4: positive shift
        og = 12'sd5; os = 12'sd10; od = -12'sd3;
        run_turns(2 * TL + 3);
        // R4: large negative shift wrapping several windows
        og = -12'sd200; os = -12'sd300; od = -12'sd500;
        run_turns(2 * TL + 3);
        // R1 again: reset in mid-run
        rst = 1;
        tick(0);
        chk(bucket_o == 11'd1 && !xing_o && !spare_o, "R1 reset mid-run", int'(bucket_o), 1);
        rst = 0;
        run_turns(50);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired: got running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule